// File: doc/BRIEF.md
# Trap Return Status Unit

This block carries out the two trap-return instructions of a core that has user, supervisor and machine privilege levels and may also have a hypervisor extension. A one-cycle request names which return to perform. The block takes in the current privilege and virtualization state, the status fields that the return reads and rewrites, the hypervisor status bits, the two saved exception PCs, and straps for the compressed-instruction, hypervisor and memory-protection features.

In the cycle after the request, the block reports either a completion strobe or an exception strobe. The exception strobe comes with a cause code. On completion the outputs carry the rewritten status fields, the new privilege and virtualization state, and the return PC. The return PC is the saved supervisor PC or the saved machine PC, chosen by the return kind. A completion that changes into a virtual context pulses a register-bank swap output. Every exception condition is checked before any state changes. When a request faults, the status and privilege outputs show the incoming values unchanged.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, `done` and `exc` are 0, `new_priv` is machine (3) and `new_virt` is 0. Privilege codes are user 0, supervisor 1, machine 3. `req_kind` 0 selects the supervisor return and 1 selects the machine return.
- R2: A supervisor return issued at user privilege raises exception cause 2 (illegal instruction).
- R3: When `has_c` is 0 and bits [1:0] of the selected return PC are not zero, the return raises cause 0 (misaligned), and all status, privilege and virtualization outputs equal the incoming values. When `has_c` is 1, low PC bits never fault.
- R4: A supervisor return with `st_tsr` set raises cause 2 below machine privilege and completes at machine privilege.
- R5: A supervisor return with `has_h` set, `cur_virt` set and `hs_vtsr` set raises cause 22 (virtual instruction).
- R6: A successful supervisor return gives sie = old spie, spie = 1 and spp = 0. `new_priv` becomes the old spp (0 or 1), and `ret_pc` becomes `sepc`.
- R7: A successful supervisor return with `has_h` set and `cur_virt` clear clears `out_hs_spv` and sets `new_virt` to the old `hs_spv`. `bank_swap` pulses when that old value is 1. With `cur_virt` set, `hs_spv` and the virtualization state are left unchanged.
- R8: A machine return issued below machine privilege raises cause 2.
- R9: A successful machine return gives mie = old mpie, mpie = 1, mpp = 0 and mpv = 0. `new_priv` becomes the old mpp, and `ret_pc` becomes `mepc`.
- R10: A machine return raises cause 1 (access fault) when `pmp_on` and `pmp_empty` are both set and the old mpp is not machine.
- R11: A successful machine return with `has_h` set gives `new_virt` = old `st_mpv`, and `bank_swap` pulses when that value is 1. Without `has_h`, the virtualization state is kept.
- R12: Exception checks are ordered. For a supervisor return the order is privilege, misalignment, trap-SRET, then virtual trap. For a machine return the order is privilege, misalignment, then protection. Only the first match is reported.
- R13: `done` or `exc` rises exactly one cycle after each request, never both at once, and for one cycle only. With no request, both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle return request |
| req_kind | input | 1 | 0 supervisor return, 1 machine return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization state |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_mpv | input | 1 | Machine previous virtualization |
| st_tsr | input | 1 | Trap supervisor return |
| hs_spv | input | 1 | Hypervisor supervisor previous virtualization |
| hs_vtsr | input | 1 | Hypervisor virtual trap of supervisor return |
| sepc | input | XLEN | Saved supervisor exception PC |
| mepc | input | XLEN | Saved machine exception PC |
| has_c | input | 1 | Compressed instructions present |
| has_h | input | 1 | Hypervisor extension present |
| pmp_on | input | 1 | Memory protection implemented |
| pmp_empty | input | 1 | No protection rules configured |
| out_sie | output | 1 | Updated sie |
| out_spie | output | 1 | Updated spie |
| out_spp | output | 1 | Updated spp |
| out_mie | output | 1 | Updated mie |
| out_mpie | output | 1 | Updated mpie |
| out_mpp | output | 2 | Updated mpp |
| out_mpv | output | 1 | Updated mpv |
| out_hs_spv | output | 1 | Updated hypervisor spv |
| new_priv | output | 2 | Resulting privilege |
| new_virt | output | 1 | Resulting virtualization |
| ret_pc | output | XLEN | Return target PC |
| done | output | 1 | Return completed |
| exc | output | 1 | Return raised an exception |
| exc_cause | output | CAUSE_W | Exception cause code |
| bank_swap | output | 1 | Pulse to swap hypervisor register banks |

## Verification
The bench builds the unit with XLEN = 32, CAUSE_W = 5 and HYP_SUPPORT = 1. With the hypervisor logic present, the bench can reach the virtual-trap fault, the previous-virtualization updates and the bank-swap pulse by toggling the `has_h` strap. With a 32-bit PC, the misalignment check can be driven on realistic addresses. A 5-bit cause width is the smallest width that holds the virtual-instruction code 22, so that code is checked with no padding.

// File: rtl/tru_pkg.sv
package tru_pkg;
   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int unsigned CODE_W = 5;
   localparam logic [CODE_W-1:0] CAUSE_MISALIGN = 5'd0;
   localparam logic [CODE_W-1:0] CAUSE_ACCESS   = 5'd1;
   localparam logic [CODE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
   localparam logic [CODE_W-1:0] CAUSE_VIRT     = 5'd22;

   typedef enum logic {
      RET_SUP  = 1'b0,
      RET_MACH = 1'b1
   } ret_kind_e;

   typedef struct packed {
      logic       sie;
      logic       spie;
      logic       spp;
      logic       mie;
      logic       mpie;
      logic [1:0] mpp;
      logic       mpv;
      logic       hspv;
   } tru_status_t;
endpackage

// File: rtl/tru_fault_order.sv
module tru_fault_order
   import tru_pkg::*;
#(
   parameter bit HYP_SUPPORT = 1'b1
) (
   input  logic                kind,
   input  logic [1:0]          cur_priv,
   input  logic                cur_virt,
   input  logic                tsr,
   input  logic                vtsr,
   input  logic [1:0]          pc_low,
   input  logic                has_c,
   input  logic                has_h,
   input  logic                pmp_on,
   input  logic                pmp_empty,
   input  logic [1:0]          old_mpp,
   output logic                fault,
   output logic [CODE_W-1:0]   cause
);
   logic hyp_on;
   logic misalign;

   generate
      if (HYP_SUPPORT) begin : g_hyp
         assign hyp_on = has_h;
      end else begin : g_nohyp
         assign hyp_on = 1'b0;
      end
   endgenerate

   assign misalign = !has_c && (pc_low != 2'b00);

   always_comb begin
      fault = 1'b0;
      cause = CAUSE_ILLEGAL;
      if (kind == RET_SUP) begin
         if (cur_priv < PRIV_S) begin
            fault = 1'b1;
            cause = CAUSE_ILLEGAL;
         end else if (misalign) begin
            fault = 1'b1;
            cause = CAUSE_MISALIGN;
         end else if (tsr && (cur_priv != PRIV_M)) begin
            fault = 1'b1;
            cause = CAUSE_ILLEGAL;
         end else if (hyp_on && cur_virt && vtsr) begin
            fault = 1'b1;
            cause = CAUSE_VIRT;
         end
      end else begin
         if (cur_priv != PRIV_M) begin
            fault = 1'b1;
            cause = CAUSE_ILLEGAL;
         end else if (misalign) begin
            fault = 1'b1;
            cause = CAUSE_MISALIGN;
         end else if (pmp_on && pmp_empty && (old_mpp != PRIV_M)) begin
            fault = 1'b1;
            cause = CAUSE_ACCESS;
         end
      end
   end
endmodule

// File: rtl/tru_state_next.sv
module tru_state_next
   import tru_pkg::*;
#(
   parameter bit HYP_SUPPORT = 1'b1
) (
   input  logic        kind,
   input  logic        cur_virt,
   input  logic        has_h,
   input  tru_status_t st_in,
   output tru_status_t st_out,
   output logic [1:0]  nxt_priv,
   output logic        nxt_virt,
   output logic        swap
);
   logic hyp_on;

   generate
      if (HYP_SUPPORT) begin : g_hyp
         assign hyp_on = has_h;
      end else begin : g_nohyp
         assign hyp_on = 1'b0;
      end
   endgenerate

   always_comb begin
      st_out   = st_in;
      nxt_virt = cur_virt;
      swap     = 1'b0;
      if (kind == RET_SUP) begin
         st_out.sie  = st_in.spie;
         st_out.spie = 1'b1;
         st_out.spp  = 1'b0;
         nxt_priv    = {1'b0, st_in.spp};
         if (hyp_on && !cur_virt) begin
            st_out.hspv = 1'b0;
            nxt_virt    = st_in.hspv;
            swap        = st_in.hspv;
         end
      end else begin
         st_out.mie  = st_in.mpie;
         st_out.mpie = 1'b1;
         st_out.mpp  = PRIV_U;
         st_out.mpv  = 1'b0;
         nxt_priv    = st_in.mpp;
         if (hyp_on) begin
            nxt_virt = st_in.mpv;
            swap     = st_in.mpv;
         end
      end
   end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
   import tru_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 5,
   parameter bit          HYP_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_kind,
   input  logic [1:0]         cur_priv,
   input  logic               cur_virt,
   input  logic               st_sie,
   input  logic               st_spie,
   input  logic               st_spp,
   input  logic               st_mie,
   input  logic               st_mpie,
   input  logic [1:0]         st_mpp,
   input  logic               st_mpv,
   input  logic               st_tsr,
   input  logic               hs_spv,
   input  logic               hs_vtsr,
   input  logic [XLEN-1:0]    sepc,
   input  logic [XLEN-1:0]    mepc,
   input  logic               has_c,
   input  logic               has_h,
   input  logic               pmp_on,
   input  logic               pmp_empty,
   output logic               out_sie,
   output logic               out_spie,
   output logic               out_spp,
   output logic               out_mie,
   output logic               out_mpie,
   output logic [1:0]         out_mpp,
   output logic               out_mpv,
   output logic               out_hs_spv,
   output logic [1:0]         new_priv,
   output logic               new_virt,
   output logic [XLEN-1:0]    ret_pc,
   output logic               done,
   output logic               exc,
   output logic [CAUSE_W-1:0] exc_cause,
   output logic               bank_swap
);
   localparam int unsigned MIN_XLEN = 16;
   localparam int unsigned MAX_XLEN = 128;

   if (XLEN < MIN_XLEN || XLEN > MAX_XLEN) begin : g_bad_xlen
      $error("trap_return_unit: XLEN out of range");
   end
   if (CAUSE_W < CODE_W) begin : g_bad_cause
      $error("trap_return_unit: CAUSE_W too narrow for cause codes");
   end

   tru_status_t       st_in, st_nxt, st_q;
   logic [XLEN-1:0]   sel_pc, pc_q;
   logic              fault;
   logic [CODE_W-1:0] cause;
   logic [1:0]        nxt_priv, priv_q;
   logic              nxt_virt, virt_q, swap_nxt;
   logic              done_q, exc_q, swap_q;
   logic [CAUSE_W-1:0] cause_q;

   assign st_in  = '{sie: st_sie, spie: st_spie, spp: st_spp, mie: st_mie,
                     mpie: st_mpie, mpp: st_mpp, mpv: st_mpv, hspv: hs_spv};
   assign sel_pc = (req_kind == RET_MACH) ? mepc : sepc;

   tru_fault_order #(.HYP_SUPPORT(HYP_SUPPORT)) u_fault (
      .kind      (req_kind),
      .cur_priv  (cur_priv),
      .cur_virt  (cur_virt),
      .tsr       (st_tsr),
      .vtsr      (hs_vtsr),
      .pc_low    (sel_pc[1:0]),
      .has_c     (has_c),
      .has_h     (has_h),
      .pmp_on    (pmp_on),
      .pmp_empty (pmp_empty),
      .old_mpp   (st_mpp),
      .fault     (fault),
      .cause     (cause)
   );

   tru_state_next #(.HYP_SUPPORT(HYP_SUPPORT)) u_next (
      .kind     (req_kind),
      .cur_virt (cur_virt),
      .has_h    (has_h),
      .st_in    (st_in),
      .st_out   (st_nxt),
      .nxt_priv (nxt_priv),
      .nxt_virt (nxt_virt),
      .swap     (swap_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= '0;
         priv_q  <= PRIV_M;
         virt_q  <= 1'b0;
         pc_q    <= '0;
         done_q  <= 1'b0;
         exc_q   <= 1'b0;
         swap_q  <= 1'b0;
         cause_q <= '0;
      end else if (req_valid) begin
         pc_q <= sel_pc;
         if (fault) begin
            st_q    <= st_in;
            priv_q  <= cur_priv;
            virt_q  <= cur_virt;
            done_q  <= 1'b0;
            exc_q   <= 1'b1;
            swap_q  <= 1'b0;
            cause_q <= CAUSE_W'(cause);
         end else begin
            st_q    <= st_nxt;
            priv_q  <= nxt_priv;
            virt_q  <= nxt_virt;
            done_q  <= 1'b1;
            exc_q   <= 1'b0;
            swap_q  <= swap_nxt;
         end
      end else begin
         done_q <= 1'b0;
         exc_q  <= 1'b0;
         swap_q <= 1'b0;
      end
   end

   assign out_sie    = st_q.sie;
   assign out_spie   = st_q.spie;
   assign out_spp    = st_q.spp;
   assign out_mie    = st_q.mie;
   assign out_mpie   = st_q.mpie;
   assign out_mpp    = st_q.mpp;
   assign out_mpv    = st_q.mpv;
   assign out_hs_spv = st_q.hspv;
   assign new_priv   = priv_q;
   assign new_virt   = virt_q;
   assign ret_pc     = pc_q;
   assign done       = done_q;
   assign exc        = exc_q;
   assign exc_cause  = cause_q;
   assign bank_swap  = swap_q;
endmodule

// File: rtl/trap_return_unit_chk.sv
module trap_return_unit_chk #(
   parameter int unsigned CAUSE_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_kind,
   input logic [1:0]         cur_priv,
   input logic               has_c,
   input logic [1:0]         mepc_lo,
   input logic               st_spp,
   input logic [1:0]         st_mpp,
   input logic               out_spie,
   input logic               out_spp,
   input logic               out_mpie,
   input logic [1:0]         out_mpp,
   input logic               out_mpv,
   input logic [1:0]         new_priv,
   input logic               done,
   input logic               exc,
   input logic [CAUSE_W-1:0] exc_cause,
   input logic               bank_swap
);
   a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && exc));

   a_r13_answer: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (done || exc));

   a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!done && !exc));

   a_r2_sret_from_user: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_kind && cur_priv == 2'd0) |=> (exc && exc_cause == CAUSE_W'(2)));

   a_r8_mret_low: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind && cur_priv != 2'd3) |=> (exc && exc_cause == CAUSE_W'(2)));

   a_r3_misalign_mret: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind && cur_priv == 2'd3 && !has_c && mepc_lo != 2'b00)
      |=> (exc && exc_cause == CAUSE_W'(0)));

   a_r6_sret_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_kind) |=> (done -> (out_spie && !out_spp &&
                                    new_priv == {1'b0, $past(st_spp)})));

   a_r9_mret_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind) |=> (done -> (out_mpie && out_mpp == 2'd0 && !out_mpv &&
                                   new_priv == $past(st_mpp))));

   a_r7_swap_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      bank_swap |-> done);
endmodule

bind trap_return_unit trap_return_unit_chk #(.CAUSE_W(CAUSE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .cur_priv  (cur_priv),
   .has_c     (has_c),
   .mepc_lo   (mepc[1:0]),
   .st_spp    (st_spp),
   .st_mpp    (st_mpp),
   .out_spie  (out_spie),
   .out_spp   (out_spp),
   .out_mpie  (out_mpie),
   .out_mpp   (out_mpp),
   .out_mpv   (out_mpv),
   .new_priv  (new_priv),
   .done      (done),
   .exc       (exc),
   .exc_cause (exc_cause),
   .bank_swap (bank_swap)
);

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;
   localparam int unsigned XLEN    = 32;
   localparam int unsigned CAUSE_W = 5;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid, req_kind;
   logic [1:0] cur_priv;
   logic cur_virt;
   logic st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpv, st_tsr;
   logic [1:0] st_mpp;
   logic hs_spv, hs_vtsr;
   logic [XLEN-1:0] sepc, mepc;
   logic has_c, has_h, pmp_on, pmp_empty;
   logic out_sie, out_spie, out_spp, out_mie, out_mpie, out_mpv, out_hs_spv;
   logic [1:0] out_mpp, new_priv;
   logic new_virt;
   logic [XLEN-1:0] ret_pc;
   logic done, exc, bank_swap;
   logic [CAUSE_W-1:0] exc_cause;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   trap_return_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HYP_SUPPORT(1'b1)) u_trap_return_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .cur_priv(cur_priv), .cur_virt(cur_virt),
      .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp), .st_mie(st_mie),
      .st_mpie(st_mpie), .st_mpp(st_mpp), .st_mpv(st_mpv), .st_tsr(st_tsr),
      .hs_spv(hs_spv), .hs_vtsr(hs_vtsr), .sepc(sepc), .mepc(mepc),
      .has_c(has_c), .has_h(has_h), .pmp_on(pmp_on), .pmp_empty(pmp_empty),
      .out_sie(out_sie), .out_spie(out_spie), .out_spp(out_spp), .out_mie(out_mie),
      .out_mpie(out_mpie), .out_mpp(out_mpp), .out_mpv(out_mpv), .out_hs_spv(out_hs_spv),
      .new_priv(new_priv), .new_virt(new_virt), .ret_pc(ret_pc),
      .done(done), .exc(exc), .exc_cause(exc_cause), .bank_swap(bank_swap)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic defaults();
      req_valid = 1'b0; req_kind = 1'b0; cur_priv = 2'd1; cur_virt = 1'b0;
      st_sie = 1'b0; st_spie = 1'b0; st_spp = 1'b0; st_mie = 1'b0; st_mpie = 1'b0;
      st_mpp = 2'd0; st_mpv = 1'b0; st_tsr = 1'b0; hs_spv = 1'b0; hs_vtsr = 1'b0;
      sepc = 32'h0000_1000; mepc = 32'h0000_2000;
      has_c = 1'b1; has_h = 1'b0; pmp_on = 1'b0; pmp_empty = 1'b0;
   endtask

   // drive a one-cycle request at a falling edge; results are registered
   // on the next rising edge and sampled at the falling edge after it
   task automatic fire(input logic kind);
      req_kind  = kind;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_exc(input string req, input logic [4:0] code);
      chk(req, "exc", exc, 1'b1);
      chk(req, "done", done, 1'b0);
      chk(req, "cause", exc_cause, code);
   endtask

   task automatic t_reset();
      chk("R1", "done", done, 1'b0);
      chk("R1", "exc", exc, 1'b0);
      chk("R1", "priv", new_priv, 2'd3);
      chk("R1", "virt", new_virt, 1'b0);
   endtask

   task automatic t_sret_ok();
      defaults(); cur_priv = 2'd1; st_spie = 1'b1; st_spp = 1'b1; st_sie = 1'b0;
      fire(1'b0);
      chk("R6", "done", done, 1'b1);
      chk("R6", "sie", out_sie, 1'b1);
      chk("R6", "spie", out_spie, 1'b1);
      chk("R6", "spp", out_spp, 1'b0);
      chk("R6", "priv", new_priv, 2'd1);
      chk("R6", "pc", ret_pc, 32'h0000_1000);
      defaults(); cur_priv = 2'd3; st_sie = 1'b1; st_spie = 1'b0; st_spp = 1'b0;
      sepc = 32'h0000_4004;
      fire(1'b0);
      chk("R6", "sie b", out_sie, 1'b0);
      chk("R6", "priv b", new_priv, 2'd0);
      chk("R6", "pc b", ret_pc, 32'h0000_4004);
   endtask

   task automatic t_sret_from_user();
      defaults(); cur_priv = 2'd0;
      fire(1'b0);
      expect_exc("R2", 5'd2);
      chk("R2", "priv", new_priv, 2'd0);
   endtask

   task automatic t_misalign();
      defaults(); cur_priv = 2'd3; has_c = 1'b0; mepc = 32'h0000_2002;
      st_mie = 1'b0; st_mpie = 1'b1; st_mpp = 2'd1;
      fire(1'b1);
      expect_exc("R3", 5'd0);
      chk("R3", "mie kept", out_mie, 1'b0);
      chk("R3", "mpp kept", out_mpp, 2'd1);
      chk("R3", "priv kept", new_priv, 2'd3);
      has_c = 1'b1;
      fire(1'b1);
      chk("R3", "done with c", done, 1'b1);
      chk("R3", "priv with c", new_priv, 2'd1);
   endtask

   task automatic t_tsr();
      defaults(); cur_priv = 2'd1; st_tsr = 1'b1;
      fire(1'b0);
      expect_exc("R4", 5'd2);
      cur_priv = 2'd3;
      fire(1'b0);
      chk("R4", "done at M", done, 1'b1);
   endtask

   task automatic t_vtsr();
      defaults(); cur_priv = 2'd1; has_h = 1'b1; cur_virt = 1'b1; hs_vtsr = 1'b1;
      fire(1'b0);
      expect_exc("R5", 5'd22);
      has_h = 1'b0;
      fire(1'b0);
      chk("R5", "done no hyp", done, 1'b1);
   endtask

   task automatic t_sret_hyp();
      defaults(); cur_priv = 2'd1; has_h = 1'b1; hs_spv = 1'b1;
      fire(1'b0);
      chk("R7", "done", done, 1'b1);
      chk("R7", "spv cleared", out_hs_spv, 1'b0);
      chk("R7", "virt", new_virt, 1'b1);
      chk("R7", "swap", bank_swap, 1'b1);
      @(negedge clk);
      chk("R7", "swap one cycle", bank_swap, 1'b0);
      hs_spv = 1'b0;
      fire(1'b0);
      chk("R7", "virt 0", new_virt, 1'b0);
      chk("R7", "no swap", bank_swap, 1'b0);
      cur_virt = 1'b1; hs_spv = 1'b1;
      fire(1'b0);
      chk("R7", "spv kept in virt", out_hs_spv, 1'b1);
      chk("R7", "virt kept", new_virt, 1'b1);
      chk("R7", "no swap in virt", bank_swap, 1'b0);
   endtask

   task automatic t_mret_low();
      defaults(); cur_priv = 2'd1;
      fire(1'b1);
      expect_exc("R8", 5'd2);
   endtask

   task automatic t_mret_ok();
      defaults(); cur_priv = 2'd3; st_mie = 1'b0; st_mpie = 1'b1; st_mpp = 2'd1; st_mpv = 1'b1;
      fire(1'b1);
      chk("R9", "done", done, 1'b1);
      chk("R9", "mie", out_mie, 1'b1);
      chk("R9", "mpie", out_mpie, 1'b1);
      chk("R9", "mpp", out_mpp, 2'd0);
      chk("R9", "mpv", out_mpv, 1'b0);
      chk("R9", "priv", new_priv, 2'd1);
      chk("R9", "pc", ret_pc, 32'h0000_2000);
      chk("R11", "virt kept no hyp", new_virt, 1'b0);
      chk("R11", "no swap no hyp", bank_swap, 1'b0);
   endtask

   task automatic t_mret_pmp();
      defaults(); cur_priv = 2'd3; pmp_on = 1'b1; pmp_empty = 1'b1; st_mpp = 2'd0;
      fire(1'b1);
      expect_exc("R10", 5'd1);
      st_mpp = 2'd3;
      fire(1'b1);
      chk("R10", "done to M", done, 1'b1);
      chk("R10", "priv M", new_priv, 2'd3);
   endtask

   task automatic t_mret_hyp();
      defaults(); cur_priv = 2'd3; has_h = 1'b1; st_mpv = 1'b1; st_mpp = 2'd1;
      fire(1'b1);
      chk("R11", "virt", new_virt, 1'b1);
      chk("R11", "swap", bank_swap, 1'b1);
      st_mpv = 1'b0;
      fire(1'b1);
      chk("R11", "virt 0", new_virt, 1'b0);
      chk("R11", "no swap", bank_swap, 1'b0);
   endtask

   task automatic t_priority();
      defaults(); cur_priv = 2'd0; has_c = 1'b0; sepc = 32'h0000_1001; st_tsr = 1'b1;
      fire(1'b0);
      expect_exc("R12", 5'd2);
      defaults(); cur_priv = 2'd1; has_c = 1'b0; sepc = 32'h0000_1002; st_tsr = 1'b1;
      has_h = 1'b1; cur_virt = 1'b1; hs_vtsr = 1'b1;
      fire(1'b0);
      expect_exc("R12", 5'd0);
      defaults(); cur_priv = 2'd3; has_c = 1'b0; mepc = 32'h0000_2003;
      pmp_on = 1'b1; pmp_empty = 1'b1; st_mpp = 2'd0;
      fire(1'b1);
      expect_exc("R12", 5'd0);
   endtask

   task automatic t_timing();
      defaults(); cur_priv = 2'd1;
      fire(1'b0);
      chk("R13", "done rises", done, 1'b1);
      @(negedge clk);
      chk("R13", "done drops", done, 1'b0);
      chk("R13", "exc quiet", exc, 1'b0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      defaults();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sret_ok();
      t_sret_from_user();
      t_misalign();
      t_tsr();
      t_vtsr();
      t_sret_hyp();
      t_mret_low();
      t_mret_ok();
      t_mret_pmp();
      t_mret_hyp();
      t_priority();
      t_timing();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule